// File: doc/BRIEF.md
# Eight-Bit Waveform Timer with One Compare Output

The block is an 8-bit counter that moves one step on each cycle in which the tick input is high. A 3-bit mode selects one of four counting schemes. Free-running mode wraps from 0xFF to 0x00. Clear-on-match mode restarts at zero after reaching compare value A. Single-slope PWM counts up and wraps at its top. Dual-slope PWM climbs to its top, turns, and descends back to zero. Depending on the mode, the top is either the all-ones value or compare value A. The encodings 4 and 6 are treated as free-running mode.

There are two compare values, A and B. Each has a holding register and an active register. The mode decides whether a write goes straight to the active register or waits in the holding register for a reload point in the count cycle. Three sticky flags record an overflow event, a match on A and a match on B. The overflow event falls at a different point in each mode.

A 2-bit output mode shapes one waveform pin from compare value B. A pin-enable output tells the pad logic whether the pin or ordinary port logic owns the pad. Every pin here is plain control or status; no datapath crosses the block's edge, so there is no handshake and no back-pressure.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0, the waveform pin is 0, the pin enable is 0, all flags are 0, mode and output mode are 0, both compare values are 0, and the counting direction is up.
- R2: The count, the direction and the waveform pin change only on a cycle with tick high. In mode 0 the count steps by one and wraps from 0xFF to 0x00. The overflow flag sets on a tick while the count is 0xFF.
- R3: In mode 2 the top is active compare value A. A tick while the count equals it loads 0 on the next edge. The overflow flag sets on a tick at 0xFF. In modes 0, 2, 4 and 6, a compare write updates the active value on the same edge.
- R4: Mode 3 (top 0xFF) and mode 7 (top = active A) count up and load 0 on a tick at top. On that tick both holding values move to the active registers. The overflow flag sets on that same tick.
- R5: Modes 1 (top 0xFF) and 5 (top = active A) count up and down. A tick steps upward when the count is 0, or when the last step was upward and the count is below top; otherwise it steps down. At top 0 the count stays 0. Holding values move to active on a tick at top. The overflow flag sets on a tick at 0.
- R6: Flag bits are [0] overflow, [1] match A, [2] match B. A flag stays set until a 1 arrives on the matching flag_clr bit. A set event and a clear in the same cycle leave the flag set.
- R7: The match A flag sets on a tick while the count equals active A. The match B flag sets on a tick while the count equals active B.
- R8: In modes 0, 2, 4 and 6, a tick with count equal to active B acts on the pin according to output mode: 01 toggles it, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R9: In modes 3 and 7 with output mode 10, a B match clears the pin and a tick at top sets it. Output mode 11 does the opposite. When both events fall on the same tick, the top action wins.
- R10: In modes 1 and 5 with output mode 10, a B match on an upward step clears the pin and a B match on a downward step sets it. Output mode 11 does the opposite.
- R11: In modes 1 and 5, when active B equals top and the output mode's high bit is 1, B matches are ignored. Instead, a tick at top sets the pin under 10 and clears it under 11.
- R12: The pin enable is 1 for output modes 10 and 11. It is 1 for 01 only in modes 0, 2, 4 and 6, and 0 otherwise. The control write (address 0) takes mode from data bits [2:0] and output mode from [5:4]. Address 1 writes A and address 2 writes B. A write to address 3 changes nothing.
- R13: Mode encodings 4 and 6 behave exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 control, 1 compare A, 2 compare B |
| wr_data | input | W | Write data |
| flag_clr | input | 3 | Per-flag clear pulses |
| count | output | W | Current count |
| wave_b | output | 1 | Waveform pin driven by compare B |
| wave_b_oe | output | 1 | Pin enable for wave_b |
| flags | output | 3 | Sticky flags: overflow, match A, match B |

## Verification
The assertions check four things on every cycle. The count and the pin hold when tick is low. Flags stay set until cleared. Clear-on-match and single-slope PWM wrap to zero at their top. Dual-slope PWM turns at top and raises the overflow flag at zero. The bench's scenarios cover the rest, running its own model in step with the design: the waveform rules of each output mode, the delayed reload of held compare values, the equal-to-top exception, the immediate write path, the ignored address, and the reserved mode encodings.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_FAST  = 2'd1,
    CLS_DUAL  = 2'd2
  } mode_cls_e;

  localparam int NFLAGS   = 3;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_MA  = 1;
  localparam int FLAG_MB  = 2;

  localparam logic [1:0] SEL_CTRL = 2'd0;

  function automatic mode_cls_e mode_class(input logic [2:0] m);
    case (m)
      3'd1, 3'd5: return CLS_DUAL;
      3'd3, 3'd7: return CLS_FAST;
      default:    return CLS_PLAIN;
    endcase
  endfunction

  function automatic logic top_is_a(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd5) || (m == 3'd7);
  endfunction

endpackage

// File: rtl/pwm_t8_regs.sv
module pwm_t8_regs
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [2:0]   mode_q,
  output logic [1:0]   com_q,
  output logic [W-1:0] a_act,
  output logic [W-1:0] b_act
);
  localparam int NCH = 2;

  logic immediate;
  assign immediate = (mode_class(mode_q) == CLS_PLAIN);

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = &{1'b0, wr_data[3], wr_data[W-1:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd0;
      com_q  <= 2'd0;
    end else if (wr_en && wr_sel == SEL_CTRL) begin
      mode_q <= wr_data[2:0];
      com_q  <= wr_data[5:4];
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    localparam logic [1:0] MY_SEL = 2'(gi + 1);
    logic [W-1:0] hold_q;
    logic [W-1:0] act_q;
    logic         hit;
    assign hit = wr_en && (wr_sel == MY_SEL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        act_q  <= '0;
      end else begin
        if (hit) hold_q <= wr_data;
        if (hit && immediate)       act_q <= wr_data;
        else if (load && !immediate) act_q <= hold_q;
      end
    end
  end

  assign a_act = g_ch[0].act_q;
  assign b_act = g_ch[1].act_q;

endmodule

// File: rtl/pwm_t8_counter.sv
module pwm_t8_counter
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  mode_cls_e    cls,
  input  logic         wrap_at_top,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] count,
  output logic         step_up,
  output logic         at_top,
  output logic         at_zero,
  output logic         at_max
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         up_q;
  logic [W-1:0] nxt;

  assign at_top  = (count == top_val);
  assign at_zero = (count == '0);
  assign at_max  = (count == '1);
  assign step_up = at_zero | (up_q & (count < top_val));

  always_comb begin
    case (cls)
      CLS_FAST: nxt = at_top ? '0 : count + ONE;
      CLS_DUAL: begin
        if (step_up) nxt = (top_val == '0) ? '0 : count + ONE;
        else         nxt = count - ONE;
      end
      default:  nxt = (wrap_at_top && at_top) ? '0 : count + ONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      count <= nxt;
      up_q  <= step_up;
    end
  end

endmodule

// File: rtl/pwm_t8_wave.sv
module pwm_t8_wave
  import pwm_timer8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  mode_cls_e  cls,
  input  logic [1:0] com,
  input  logic       match_b,
  input  logic       at_top,
  input  logic       step_up,
  input  logic       b_is_top,
  output logic       wave,
  output logic       oe
);
  logic nxt;

  always_comb begin
    nxt = wave;
    if (tick) begin
      case (cls)
        CLS_PLAIN: begin
          if (match_b) begin
            case (com)
              2'b01:   nxt = ~wave;
              2'b10:   nxt = 1'b0;
              2'b11:   nxt = 1'b1;
              default: nxt = wave;
            endcase
          end
        end
        CLS_FAST: begin
          if (com[1]) begin
            if (at_top)       nxt = ~com[0];
            else if (match_b) nxt = com[0];
          end
        end
        CLS_DUAL: begin
          if (com[1]) begin
            if (b_is_top) begin
              if (at_top) nxt = ~com[0];
            end else if (match_b) begin
              nxt = step_up ? com[0] : ~com[0];
            end
          end
        end
        default: nxt = wave;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= nxt;
  end

  assign oe = (com != 2'b00) && !((com == 2'b01) && (cls != CLS_PLAIN));

endmodule

// File: rtl/pwm_t8_flags.sv
module pwm_t8_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[gi] <= 1'b0;
      else if (set[gi]) q[gi] <= 1'b1;
      else if (clr[gi]) q[gi] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [W-1:0]      wr_data,
  input  logic [NFLAGS-1:0] flag_clr,
  output logic [W-1:0]      count,
  output logic              wave_b,
  output logic              wave_b_oe,
  output logic [NFLAGS-1:0] flags
);
  logic [2:0]        mode_q;
  logic [1:0]        com_q;
  logic [W-1:0]      a_act, b_act, top_val;
  mode_cls_e         cls;
  logic              step_up, at_top, at_zero, at_max;
  logic              load, ovf_ev;
  logic [NFLAGS-1:0] flag_set;

  assign cls     = mode_class(mode_q);
  assign top_val = top_is_a(mode_q) ? a_act : '1;
  assign load    = tick && (cls != CLS_PLAIN) && at_top;

  always_comb begin
    case (cls)
      CLS_DUAL: ovf_ev = at_zero;
      CLS_FAST: ovf_ev = at_top;
      default:  ovf_ev = at_max;
    endcase
    flag_set           = '0;
    flag_set[FLAG_OVF] = tick && ovf_ev;
    flag_set[FLAG_MA]  = tick && (count == a_act);
    flag_set[FLAG_MB]  = tick && (count == b_act);
  end

  pwm_t8_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .load(load), .mode_q(mode_q), .com_q(com_q),
    .a_act(a_act), .b_act(b_act)
  );

  pwm_t8_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cls(cls),
    .wrap_at_top(mode_q == 3'd2), .top_val(top_val), .count(count),
    .step_up(step_up), .at_top(at_top), .at_zero(at_zero), .at_max(at_max)
  );

  pwm_t8_wave u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cls(cls), .com(com_q),
    .match_b(count == b_act), .at_top(at_top), .step_up(step_up),
    .b_is_top(b_act == top_val), .wave(wave_b), .oe(wave_b_oe)
  );

  pwm_t8_flags #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flags)
  );

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [2:0]   flag_clr,
  input logic [W-1:0] count,
  input logic [2:0]   flags,
  input logic         wave_b,
  input logic [2:0]   mode_q,
  input logic [W-1:0] top_val,
  input logic [W-1:0] a_act
);
  logic dual, fast;
  assign dual = (mode_q == 3'd1) || (mode_q == 3'd5);
  assign fast = (mode_q == 3'd3) || (mode_q == 3'd7);

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  p_wave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave_b));

  p_ctc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_q == 3'd2 && count == a_act) |=> (count == '0));

  p_fast_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && count == top_val) |=> (count == '0));

  p_dual_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dual && count == top_val && top_val != '0)
      |=> (count == $past(top_val) - W'(1)));

  p_dual_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dual && count == '0) |=> flags[0]);

  for (genvar gi = 0; gi < 3; gi++) begin : g_sticky
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[gi] && !flag_clr[gi]) |=> flags[gi]);
  end

endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .flag_clr(flag_clr),
  .count(count), .flags(flags), .wave_b(wave_b), .mode_q(mode_q),
  .top_val(top_val), .a_act(a_act)
);

// File: tb/pwm_timer8_bench.sv
`timescale 1ns/1ps
module pwm_timer8_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] flag_clr = 3'd0;
  logic [7:0] count;
  logic       wave_b, wave_b_oe;
  logic [2:0] flags;

  always #4 clk = ~clk;

  pwm_timer8 #(.W(8)) u_pwm_timer8 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .flag_clr(flag_clr), .count(count), .wave_b(wave_b),
    .wave_b_oe(wave_b_oe), .flags(flags)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit live = 0;

  int m_cnt, m_up, m_mode, m_com, m_abuf, m_bbuf, m_a, m_b, m_wave, m_flags;
  int k_cls, k_top, k_up, k_nxt, k_ld, k_set;

  function automatic int cls_of(int m);
    if (m == 1 || m == 5) return 2;
    if (m == 3 || m == 7) return 1;
    return 0;
  endfunction

  function automatic int top_of(int m, int a);
    return (m == 2 || m == 5 || m == 7) ? a : 255;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_mode = 0; m_com = 0; m_abuf = 0; m_bbuf = 0;
      m_a = 0; m_b = 0; m_wave = 0; m_flags = 0;
    end else begin
      k_cls = cls_of(m_mode);
      k_top = top_of(m_mode, m_a);
      k_set = 0;
      k_ld = 0;
      if (tick) begin
        k_up = ((m_cnt == 0) || (m_up != 0 && m_cnt < k_top)) ? 1 : 0;
        if (k_cls == 0) begin
          k_nxt = (m_mode == 2 && m_cnt == m_a) ? 0 : (m_cnt + 1) % 256;
          if (m_cnt == 255) k_set |= 1;
          if (m_cnt == m_b) begin
            if (m_com == 1) m_wave = 1 - m_wave;
            else if (m_com == 2) m_wave = 0;
            else if (m_com == 3) m_wave = 1;
          end
        end else if (k_cls == 1) begin
          k_nxt = (m_cnt == k_top) ? 0 : (m_cnt + 1) % 256;
          if (m_cnt == k_top) begin k_set |= 1; k_ld = 1; end
          if (m_com >= 2) begin
            if (m_cnt == k_top) m_wave = (m_com == 2) ? 1 : 0;
            else if (m_cnt == m_b) m_wave = (m_com == 3) ? 1 : 0;
          end
        end else begin
          k_nxt = (k_up != 0) ? ((k_top == 0) ? 0 : m_cnt + 1) : m_cnt - 1;
          if (m_cnt == 0) k_set |= 1;
          if (m_cnt == k_top) k_ld = 1;
          if (m_com >= 2) begin
            if (m_b == k_top) begin
              if (m_cnt == k_top) m_wave = (m_com == 2) ? 1 : 0;
            end else if (m_cnt == m_b) begin
              if (k_up != 0) m_wave = (m_com == 3) ? 1 : 0;
              else           m_wave = (m_com == 2) ? 1 : 0;
            end
          end
        end
        if (m_cnt == m_a) k_set |= 2;
        if (m_cnt == m_b) k_set |= 4;
        m_cnt = k_nxt;
        m_up = k_up;
        if (k_ld != 0) begin m_a = m_abuf; m_b = m_bbuf; end
      end
      m_flags = ((m_flags & ~int'(flag_clr)) | k_set) & 7;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin m_mode = wr_data & 7; m_com = (wr_data >> 4) & 3; end
          2'd1: begin m_abuf = wr_data; if (k_cls == 0) m_a = wr_data; end
          2'd2: begin m_bbuf = wr_data; if (k_cls == 0) m_b = wr_data; end
          default: ; // R12: address 3 has no effect
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic string cnt_tag(int m);
    case (m)
      0: return "R2 count";
      2: return "R3 count";
      3, 7: return "R4 count";
      1, 5: return "R5 count";
      default: return "R13 count";
    endcase
  endfunction

  function automatic string wave_tag();
    int c = cls_of(m_mode);
    if (c == 0) return "R8 wave";
    if (c == 1) return "R9 wave";
    if (m_b == top_of(m_mode, m_a)) return "R11 wave";
    return "R10 wave";
  endfunction

  always @(negedge clk) begin
    if (live) begin
      chk(cnt_tag(m_mode), int'(count), m_cnt);
      chk(wave_tag(), int'(wave_b), m_wave);
      chk("R12 pin enable", int'(wave_b_oe),
          (m_com == 0) ? 0 : (m_com == 1 ? (cls_of(m_mode) == 0 ? 1 : 0) : 1));
      chk("R6/R7 flags", int'(flags), m_flags);
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected<=%0d", cycles, 60000);
      finish_run();
    end
  end

  task automatic wr(input int sel, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl(input int m, input int c);
    wr(0, m | (c << 4));
  endtask

  task automatic run(input int n, input int tmod);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (tmod <= 1) ? 1'b1 : ((i % tmod) != 0);
      if (i % 37 == 5)       flag_clr = 3'b111;
      else if (i % 53 == 11) flag_clr = 3'b001;
      else                   flag_clr = 3'b000;
    end
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 count", int'(count), 0);
    chk("R1 wave", int'(wave_b), 0);
    chk("R1 pin enable", int'(wave_b_oe), 0);
    chk("R1 flags", int'(flags), 0);
    live = 1;

    // R2 / R8: free-running, toggle on B, immediate writes, gated ticks
    wr(2, 16);
    ctl(0, 1);
    run(600, 1);
    wr(2, 200);
    run(300, 3);
    // R12: address 3 write must leave everything untouched
    tick = 1'b0;
    wr(3, 8'h7F);
    run(4, 1000);
    ctl(0, 3);
    run(300, 1);

    // R3: clear-on-match with tops 20 and 0, output modes 11 then 10
    wr(1, 20);
    ctl(2, 3);
    wr(2, 7);
    run(200, 2);
    ctl(2, 2);
    run(120, 1);
    wr(1, 0);
    run(20, 1);

    // R4 / R9: single-slope with top 0xFF, buffered B change mid-cycle
    ctl(3, 2);
    wr(2, 64);
    run(400, 1);
    wr(2, 255);
    run(600, 1);
    ctl(3, 1);
    run(100, 1);

    // R4 / R9: single-slope with top from A, B below and equal to top
    wr(1, 50);
    ctl(7, 3);
    wr(2, 20);
    run(300, 1);
    wr(2, 50);
    run(200, 1);
    wr(1, 30);
    run(200, 2);

    // R5 / R10: dual-slope with top 0xFF
    ctl(1, 2);
    wr(2, 128);
    run(1100, 1);
    wr(2, 0);
    ctl(1, 3);
    run(1100, 1);

    // R5 / R11: dual-slope with top from A, B equal to top then below
    wr(1, 40);
    ctl(5, 2);
    wr(2, 40);
    run(400, 1);
    ctl(5, 3);
    run(300, 1);
    wr(2, 12);
    run(300, 1);
    ctl(5, 1);
    run(100, 1);
    wr(1, 0);
    run(200, 1);

    // R13: reserved encodings behave as free-running
    ctl(4, 1);
    wr(2, 99);
    run(600, 1);
    ctl(6, 3);
    wr(2, 3);
    run(600, 2);

    live = 0;
    finish_run();
  end

endmodule